// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address by reading a four-level tree of translation tables from memory. Only 4 KiB pages are supported. A requester hands over a virtual address, the kind of access (write, user, execute) and the physical base of the top-level table. The walker first checks that the address is canonical. It then reads one 64-bit entry per level through a memory request/response port. When the walk ends it reports either the physical address with the combined permission flags, or a fault code together with the level at which the walk stopped.

Both streaming edges follow valid/ready rules. A translation request is taken in the cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while the walker is idle, so a requester that holds `req_valid` is simply kept waiting. Once the walker raises `mem_req_valid`, it holds the valid signal and the address steady until memory accepts with `mem_req_ready`. Memory may stall for any number of cycles. The response is a single-cycle `mem_rsp_valid` pulse, and the walker always accepts it because it has only one read outstanding. Results come out as a one-cycle `done` pulse, and `busy` brackets the whole walk.

Fault codes on `done_fault`: 0 = translated, 1 = non-canonical, 2 = entry not present, 3 = reserved bit set, 4 = permission denied. Levels on `done_level` are numbered 3 for the top table down to 0 for the leaf.

Top module: `pt_walker`

## Requirements
- R1: An accepted address whose bits 63..47 are not all equal ends with `done` and fault code 1 in the cycle after acceptance, and no memory read is issued for it. Addresses in the upper canonical half are walked normally.
- R2: The walker makes at most four reads, in order from level 3 down to level 0. Each read uses index bits 47:39, 38:30, 29:21 and 20:12 respectively. The read address is the table base plus 8 times the index, so every read address is 8-byte aligned.
- R3: Level 3 uses the base from `root_base`. Each later table base is taken from bits PA_W-1:12 of the entry read at the previous level. A successful walk returns the leaf entry's bits PA_W-1:12 as physical address bits PA_W-1:12, and passes virtual address bits 11:0 through unchanged. It reports fault 0 and level 0.
- R4: An entry whose bit 0 (present) is clear stops the walk at once with fault code 2 and reports the level of that entry. No further reads are made.
- R5: An entry with any bit in 51:PA_W set stops the walk with fault code 3 and reports the level of that entry. Bits below PA_W (for example bit 45 with PA_W = 46) are ordinary address bits.
- R6: On success, `done_wr` is the AND of bit 1 over all four entries, `done_usr` is the AND of bit 2, and `done_xd` is the OR of bit 63.
- R7: After a full walk, the result is fault code 4 at level 0 in any of three cases: a write request when the combined write flag is clear, a user request when the combined user flag is clear, or an execute request when the combined execute-disable flag is set.
- R8: `req_ready` is high exactly when the walker is idle. `busy` stays high from the cycle after acceptance up to and including the `done` cycle. `done` lasts one cycle. A request held during a walk is not taken.
- R9: While `mem_req_valid` is high and not yet accepted, it stays high and `mem_req_addr` stays stable.
- R10: After reset the walker is idle: `req_ready` is 1, and `busy`, `done` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user privilege |
| req_exec | input | 1 | Access is an instruction fetch |
| root_base | input | PA_W | Physical base of the level-3 table (bits 11:0 ignored) |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | PA_W | Physical byte address of the entry |
| mem_rsp_valid | input | 1 | Read data valid (single cycle) |
| mem_rsp_data | input | 64 | Entry contents |
| done | output | 1 | One-cycle result strobe |
| done_fault | output | 3 | Fault code, 0 when translated |
| done_level | output | 2 | Level where the walk ended |
| done_paddr | output | PA_W | Translated physical address (0 on fault) |
| done_wr | output | 1 | Combined write permission |
| done_usr | output | 1 | Combined user permission |
| done_xd | output | 1 | Combined execute-disable |

## Verification
The assertions assume that memory sends `mem_rsp_valid` only for a read it has already accepted, and never more than one response per read. They also assume that request fields are meaningful only while `req_valid` is high. The bench memory model follows these rules: it raises `mem_req_ready` for exactly one cycle per read, after a chosen stall, and answers once after a chosen latency. Request inputs are changed only on falling edges, and `req_valid` is raised only while the walker reports idle. The one exception is the hold test, where it is deliberately kept high during a walk to show that the request is not taken.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    PW_OK       = 3'd0,
    PW_NONCANON = 3'd1,
    PW_ABSENT   = 3'd2,
    PW_RSVD     = 3'd3,
    PW_PERM     = 3'd4
  } pw_fault_e;

  typedef enum logic [1:0] {
    WS_IDLE  = 2'd0,
    WS_ISSUE = 2'd1,
    WS_WAIT  = 2'd2,
    WS_FIN   = 2'd3
  } pw_state_e;

  localparam int unsigned ENTRY_W   = 64;
  localparam int unsigned BIT_PRES  = 0;
  localparam int unsigned BIT_WR    = 1;
  localparam int unsigned BIT_USR   = 2;
  localparam int unsigned BIT_XD    = 63;
  localparam int unsigned PA_LIMIT  = 52;

endpackage

// File: rtl/pw_canon_check.sv
module pw_canon_check #(
  parameter int unsigned VA_W = 48
) (
  input  logic [63:0] vaddr,
  output logic        canon_ok
);
  localparam int unsigned TOP_N = 64 - VA_W + 1;

  logic [TOP_N-1:0] upper;

  always_comb begin
    upper    = vaddr[63:VA_W-1];
    canon_ok = (&upper) | ~(|upper);
  end

  logic unused_low;
  assign unused_low = ^vaddr[VA_W-2:0];
endmodule

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PG_W   = 12,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned VA_W  = PG_W + IDX_W * LEVELS
) (
  input  logic [VA_W-1:PG_W] vpn,
  input  logic [LVL_W-1:0]   level,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] field [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_field
    assign field[l] = vpn[PG_W + IDX_W*l +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (level == LVL_W'(l)) idx = field[l];
    end
  end
endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned PA_W = 46,
  parameter int unsigned PG_W = 12
) (
  input  logic [ENTRY_W-1:0]   entry,
  output logic                 present,
  output logic                 resv_err,
  output logic                 perm_wr,
  output logic                 perm_usr,
  output logic                 exec_dis,
  output logic [PA_W-PG_W-1:0] next_base
);
  assign present   = entry[BIT_PRES];
  assign perm_wr   = entry[BIT_WR];
  assign perm_usr  = entry[BIT_USR];
  assign exec_dis  = entry[BIT_XD];
  assign next_base = entry[PA_W-1:PG_W];

  if (PA_W < PA_LIMIT) begin : g_resv
    assign resv_err = |entry[PA_LIMIT-1:PA_W];
  end else begin : g_no_resv
    assign resv_err = 1'b0;
  end

  logic unused_fields;
  assign unused_fields = ^{entry[62:PA_LIMIT], entry[PG_W-1:3]};
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned PG_W   = 12,
  parameter int unsigned PA_W   = 46,
  localparam int unsigned LVL_W = $clog2(LEVELS),
  localparam int unsigned VA_W  = PG_W + IDX_W * LEVELS,
  localparam int unsigned BASE_W = PA_W - PG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [63:0]       req_vaddr,
  input  logic              req_write,
  input  logic              req_user,
  input  logic              req_exec,
  input  logic [PA_W-1:0]   root_base,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [63:0]       mem_rsp_data,
  output logic              done,
  output logic [2:0]        done_fault,
  output logic [LVL_W-1:0]  done_level,
  output logic [PA_W-1:0]   done_paddr,
  output logic              done_wr,
  output logic              done_usr,
  output logic              done_xd
);
  localparam int unsigned ENT_SH = 3;

  pw_state_e         state_q;
  logic [VA_W-1:0]   vaddr_q;
  logic              wr_q, usr_q, exec_q;
  logic [BASE_W-1:0] base_q;
  logic [LVL_W-1:0]  level_q;
  logic              acc_wr_q, acc_usr_q, acc_xd_q;
  pw_fault_e         fault_q;
  logic [LVL_W-1:0]  end_level_q;
  logic [PA_W-1:0]   paddr_q;

  logic              canon_ok;
  logic [IDX_W-1:0]  idx;
  logic              ent_present, ent_resv, ent_wr, ent_usr, ent_xd;
  logic [BASE_W-1:0] ent_base;
  logic              nxt_wr, nxt_usr, nxt_xd, perm_bad;

  pw_canon_check #(.VA_W(VA_W)) u_canon (
    .vaddr    (req_vaddr),
    .canon_ok (canon_ok)
  );

  pw_index_sel #(.LEVELS(LEVELS), .IDX_W(IDX_W), .PG_W(PG_W)) u_idx (
    .vpn   (vaddr_q[VA_W-1:PG_W]),
    .level (level_q),
    .idx   (idx)
  );

  pw_entry_decode #(.PA_W(PA_W), .PG_W(PG_W)) u_dec (
    .entry     (mem_rsp_data),
    .present   (ent_present),
    .resv_err  (ent_resv),
    .perm_wr   (ent_wr),
    .perm_usr  (ent_usr),
    .exec_dis  (ent_xd),
    .next_base (ent_base)
  );

  // Flags accumulated including the entry arriving now.
  always_comb begin
    nxt_wr   = acc_wr_q & ent_wr;
    nxt_usr  = acc_usr_q & ent_usr;
    nxt_xd   = acc_xd_q | ent_xd;
    perm_bad = (wr_q & ~nxt_wr) | (usr_q & ~nxt_usr) | (exec_q & nxt_xd);
  end

  // Tables are page aligned, so the entry address is a plain concatenation.
  assign mem_req_addr  = {base_q, idx, {ENT_SH{1'b0}}};
  assign mem_req_valid = (state_q == WS_ISSUE);
  assign req_ready     = (state_q == WS_IDLE);
  assign busy          = (state_q != WS_IDLE);
  assign done          = (state_q == WS_FIN);
  assign done_fault    = fault_q;
  assign done_level    = end_level_q;
  assign done_paddr    = paddr_q;
  assign done_wr       = acc_wr_q;
  assign done_usr      = acc_usr_q;
  assign done_xd       = acc_xd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= WS_IDLE;
      vaddr_q     <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      exec_q      <= 1'b0;
      base_q      <= '0;
      level_q     <= '0;
      acc_wr_q    <= 1'b0;
      acc_usr_q   <= 1'b0;
      acc_xd_q    <= 1'b0;
      fault_q     <= PW_OK;
      end_level_q <= '0;
      paddr_q     <= '0;
    end else begin
      unique case (state_q)
        WS_IDLE: begin
          if (req_valid) begin
            vaddr_q     <= req_vaddr[VA_W-1:0];
            wr_q        <= req_write;
            usr_q       <= req_user;
            exec_q      <= req_exec;
            base_q      <= root_base[PA_W-1:PG_W];
            level_q     <= LVL_W'(LEVELS-1);
            acc_wr_q    <= 1'b1;
            acc_usr_q   <= 1'b1;
            acc_xd_q    <= 1'b0;
            paddr_q     <= '0;
            end_level_q <= LVL_W'(LEVELS-1);
            if (!canon_ok) begin
              fault_q <= PW_NONCANON;
              state_q <= WS_FIN;
            end else begin
              fault_q <= PW_OK;
              state_q <= WS_ISSUE;
            end
          end
        end
        WS_ISSUE: begin
          if (mem_req_ready) state_q <= WS_WAIT;
        end
        WS_WAIT: begin
          if (mem_rsp_valid) begin
            end_level_q <= level_q;
            if (!ent_present) begin
              fault_q <= PW_ABSENT;
              state_q <= WS_FIN;
            end else if (ent_resv) begin
              fault_q <= PW_RSVD;
              state_q <= WS_FIN;
            end else begin
              acc_wr_q  <= nxt_wr;
              acc_usr_q <= nxt_usr;
              acc_xd_q  <= nxt_xd;
              if (level_q == '0) begin
                if (perm_bad) begin
                  fault_q <= PW_PERM;
                end else begin
                  fault_q <= PW_OK;
                  paddr_q <= {ent_base, vaddr_q[PG_W-1:0]};
                end
                state_q <= WS_FIN;
              end else begin
                base_q  <= ent_base;
                level_q <= level_q - LVL_W'(1);
                state_q <= WS_ISSUE;
              end
            end
          end
        end
        WS_FIN: begin
          state_q <= WS_IDLE;
        end
        default: state_q <= WS_IDLE;
      endcase
    end
  end

  logic unused_root;
  assign unused_root = ^root_base[PG_W-1:0];
endmodule

// File: rtl/pt_walker_checks.sv
module pt_walker_checks #(
  parameter int unsigned PA_W  = 46,
  parameter int unsigned LVL_W = 2,
  parameter int unsigned VA_W  = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [63:0]      req_vaddr,
  input logic             busy,
  input logic             mem_req_valid,
  input logic             mem_req_ready,
  input logic [PA_W-1:0]  mem_req_addr,
  input logic             done,
  input logic [2:0]       done_fault,
  input logic [LVL_W-1:0] done_level
);
  logic canon_in;
  assign canon_in = (&req_vaddr[63:VA_W-1]) | ~(|req_vaddr[63:VA_W-1]);

  assert_noncanon_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !canon_in) |=> (done && done_fault == 3'd1));

  assert_noncanon_noread_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !canon_in) |=> !mem_req_valid);

  assert_read_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'd0));

  assert_ok_leaf_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 3'd0) |-> (done_level == '0));

  assert_perm_leaf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_fault == 3'd4) |-> (done_level == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy);

  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid);
endmodule

bind pt_walker pt_walker_checks #(.PA_W(PA_W), .LVL_W(LVL_W), .VA_W(VA_W)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_vaddr     (req_vaddr),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done          (done),
  .done_fault    (done_fault),
  .done_level    (done_level)
);

// File: tb/pt_walker_test.sv
`timescale 1ns/1ps
module pt_walker_test;
  localparam int PA_W = 46;
  localparam logic [63:0] P  = 64'h1;
  localparam logic [63:0] W  = 64'h2;
  localparam logic [63:0] U  = 64'h4;
  localparam logic [63:0] XD = 64'h8000_0000_0000_0000;
  localparam logic [63:0] PAGE = 64'h0000_0002_ABCD_E000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [PA_W-1:0] root_base = PA_W'(64'h1000);
  logic req_ready, busy, mem_req_valid, done, done_wr, done_usr, done_xd;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic [PA_W-1:0] mem_req_addr, done_paddr;
  logic [2:0] done_fault;
  logic [1:0] done_level;

  always #4 clk = ~clk;

  pt_walker uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_user(req_user),
    .req_exec(req_exec), .root_base(root_base), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
    .done_level(done_level), .done_paddr(done_paddr), .done_wr(done_wr),
    .done_usr(done_usr), .done_xd(done_xd)
  );

  int n_checks = 0, n_fail = 0;
  logic [63:0] mem [4096];
  int stall = 0, lat = 2;
  int rd_n = 0;
  logic [63:0] rd_addr [8];
  bit busy_gap = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Memory model: one read at a time, with stall before accept and latency after.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (mem_req_valid) begin
        repeat (stall) @(negedge clk);
        if (rd_n < 8) rd_addr[rd_n] = 64'(mem_req_addr);
        rd_n++;
        mem_rsp_data = mem[(mem_req_addr >> 3) & 4095];
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  function automatic logic [63:0] mkva(input int i3, i2, i1, i0, input int off);
    logic [63:0] v;
    v = (64'(i3) << 39) | (64'(i2) << 30) | (64'(i1) << 21) | (64'(i0) << 12) | 64'(off);
    if (v[47]) v[63:48] = 16'hFFFF;
    return v;
  endfunction

  task automatic build(input int i3, i2, i1, i0, input logic [63:0] f3, f2, f1, f0);
    for (int k = 0; k < 4096; k++) mem[k] = '0;
    mem[(64'h1000 + 64'(i3) * 8) >> 3] = 64'h2000 | f3;
    mem[(64'h2000 + 64'(i2) * 8) >> 3] = 64'h3000 | f2;
    mem[(64'h3000 + 64'(i1) * 8) >> 3] = 64'h4000 | f1;
    mem[(64'h4000 + 64'(i0) * 8) >> 3] = PAGE | f0;
  endtask

  task automatic issue(input logic [63:0] va, input bit wr, usr, ex);
    @(negedge clk);
    rd_n = 0;
    req_vaddr = va; req_write = wr; req_user = usr; req_exec = ex;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    busy_gap = 0;
    while (!done && cyc < 300) begin
      if (!busy || req_ready) busy_gap = 1;
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R10 ready after reset", 64'(req_ready), 1);
    chk(busy == 1'b0 && done == 1'b0, "R10 busy/done after reset", 64'({busy, done}), 0);
    chk(mem_req_valid == 1'b0, "R10 no read after reset", 64'(mem_req_valid), 0);
  endtask

  task automatic t_basic_walk();
    int c;
    logic [63:0] va = mkva(9'h1A5, 9'h003, 9'h0FF, 9'h100, 12'h9C4);
    build(9'h1A5, 9'h003, 9'h0FF, 9'h100, P|W|U, P|W|U, P|W|U, P|W|U);
    issue(va, 1, 1, 1);
    wait_done(c);
    chk(done_fault == 3'd0, "R3 fault code", 64'(done_fault), 0);
    chk(64'(done_paddr) == (PAGE | 64'h9C4), "R3 physical address", 64'(done_paddr), PAGE | 64'h9C4);
    chk(done_level == 2'd0, "R3 level", 64'(done_level), 0);
    chk(rd_n == 4, "R2 read count", 64'(rd_n), 4);
    chk(rd_addr[0] == 64'h1000 + 9'h1A5 * 8, "R2 level-3 address", rd_addr[0], 64'h1000 + 9'h1A5 * 8);
    chk(rd_addr[1] == 64'h2000 + 9'h003 * 8, "R2 level-2 address", rd_addr[1], 64'h2000 + 9'h003 * 8);
    chk(rd_addr[2] == 64'h3000 + 9'h0FF * 8, "R2 level-1 address", rd_addr[2], 64'h3000 + 9'h0FF * 8);
    chk(rd_addr[3] == 64'h4000 + 9'h100 * 8, "R2 level-0 address", rd_addr[3], 64'h4000 + 9'h100 * 8);
    chk({done_wr, done_usr, done_xd} == 3'b110, "R6 flags all granted", 64'({done_wr, done_usr, done_xd}), 64'b110);
    chk(busy_gap == 0, "R8 busy through walk", 64'(busy_gap), 0);
    @(negedge clk);
    chk(done == 1'b0 && req_ready == 1'b1, "R8 done one cycle then idle", 64'({done, req_ready}), 1);
  endtask

  task automatic t_noncanon();
    int c;
    issue(64'h0000_8000_0000_0000, 0, 0, 0);
    chk(done == 1'b1, "R1 done next cycle", 64'(done), 1);
    chk(done_fault == 3'd1, "R1 fault code", 64'(done_fault), 1);
    chk(rd_n == 0, "R1 no memory read", 64'(rd_n), 0);
    issue(64'hFFFE_FFFF_FFFF_F000, 0, 0, 0);
    chk(done == 1'b1 && done_fault == 3'd1, "R1 high non-canonical", 64'(done_fault), 1);
    build(9'h1FF, 9'h1FF, 9'h000, 9'h001, P|W|U, P|W|U, P|W|U, P|W|U);
    issue(mkva(9'h1FF, 9'h1FF, 9'h000, 9'h001, 12'h010), 0, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd0 && 64'(done_paddr) == (PAGE | 64'h10), "R1 upper half walked", 64'(done_paddr), PAGE | 64'h10);
  endtask

  task automatic t_absent();
    int c;
    build(9'h011, 9'h022, 9'h033, 9'h044, P|W|U, W|U, P|W|U, P|W|U);
    issue(mkva(9'h011, 9'h022, 9'h033, 9'h044, 0), 0, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd2, "R4 not-present code", 64'(done_fault), 2);
    chk(done_level == 2'd2, "R4 level reported", 64'(done_level), 2);
    chk(rd_n == 2, "R4 walk stops", 64'(rd_n), 2);
  endtask

  task automatic t_reserved();
    int c;
    build(9'h005, 9'h006, 9'h007, 9'h008, P|W|U, P|W|U, P|W|U, P|W|U | (64'h1 << 50));
    issue(mkva(9'h005, 9'h006, 9'h007, 9'h008, 0), 0, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd3, "R5 reserved code", 64'(done_fault), 3);
    chk(done_level == 2'd0, "R5 reserved level", 64'(done_level), 0);
    build(9'h005, 9'h006, 9'h007, 9'h008, P|W|U, P|W|U, P|W|U, P|W|U | (64'h1 << 45));
    issue(mkva(9'h005, 9'h006, 9'h007, 9'h008, 12'h123), 0, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd0 && 64'(done_paddr) == (PAGE | (64'h1 << 45) | 64'h123),
        "R5 bit 45 is address", 64'(done_paddr), PAGE | (64'h1 << 45) | 64'h123);
  endtask

  task automatic t_perms();
    int c;
    build(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, P|W|U|XD, P|W, P|W|U, P|W|U);
    issue(mkva(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, 0), 1, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd0, "R7 write allowed", 64'(done_fault), 0);
    chk({done_wr, done_usr, done_xd} == 3'b101, "R6 combined flags", 64'({done_wr, done_usr, done_xd}), 64'b101);
    issue(mkva(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, 0), 0, 1, 0);
    wait_done(c);
    chk(done_fault == 3'd4 && done_level == 0, "R7 user denied", 64'(done_fault), 4);
    issue(mkva(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, 0), 0, 0, 1);
    wait_done(c);
    chk(done_fault == 3'd4, "R7 execute denied", 64'(done_fault), 4);
    chk(rd_n == 4, "R7 full walk before check", 64'(rd_n), 4);
    build(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, P|W|U, P|U, P|W|U, P|W|U);
    issue(mkva(9'h0A0, 9'h0B0, 9'h0C0, 9'h0D0, 0), 1, 0, 0);
    wait_done(c);
    chk(done_fault == 3'd4, "R7 write denied", 64'(done_fault), 4);
  endtask

  task automatic t_hold_and_stall();
    int c;
    stall = 3; lat = 4;
    build(9'h077, 9'h066, 9'h055, 9'h044, P|W|U, P|W|U, P|W|U, P|W|U);
    issue(mkva(9'h077, 9'h066, 9'h055, 9'h044, 12'hABC), 0, 0, 0);
    req_vaddr = 64'h0000_8000_0000_0000;
    req_valid = 1'b1;
    repeat (6) @(negedge clk);
    chk(req_ready == 1'b0, "R8 not ready mid-walk", 64'(req_ready), 0);
    req_valid = 1'b0;
    wait_done(c);
    chk(done_fault == 3'd0 && 64'(done_paddr) == (PAGE | 64'hABC), "R9 stalled walk result", 64'(done_paddr), PAGE | 64'hABC);
    chk(rd_n == 4, "R8 held request not taken", 64'(rd_n), 4);
    stall = 0; lat = 2;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_walk();
    t_noncanon();
    t_absent();
    t_reserved();
    t_perms();
    t_hold_and_stall();
    repeat (4) @(negedge clk);
    summary();
  end
endmodule